// File: doc/BRIEF.md
# Floating-Point Issue Hazard Scoreboard

This block decides, cycle by cycle, whether the instruction a floating-point coprocessor is being offered may start now. Each candidate carries an operation class code, two source register numbers and a destination register number. The block also sees a flag from the integer core that says the core is held in its first execute stage. From these inputs it raises either a go or a stall. Alongside that answer it gives the number of cycles still to wait before the candidate could start.

Two kinds of hazard are tracked. The structural kind covers the occupancy of the multiply-add unit, the divide/square-root unit and three load/store slots; the flag transfer in addition waits for both execution units to drain. The data kind covers each of the 32 registers, which holds a countdown to the cycle its pending result can be read. Arithmetic consumers read one cycle earlier than other consumers because of forwarding. The reported wait is the larger of the structural and data waits.

The candidate is held at the inputs until it is granted. A granted instruction books its resources on the clock edge that follows the grant.

Top module: `fpsb_issue`

## Requirements
- R1: Operation codes are 0 fast op, 1 arithmetic, 2 conversion, 3 double multiply, 4 single divide/sqrt, 5 double divide/sqrt, 6 single load or core-to-coprocessor move, 7 double load, 8 single store, 9 double store, 10 flag transfer. After a synchronous reset no unit and no register is busy, so any code is granted at once with wait 0.
- R2: While core_hold is high, issue_go stays low. A valid candidate raises issue_stall instead, and the held candidate reserves nothing.
- R3: Codes 0, 1, 2 and 5 occupy the multiply-add unit only in their issue cycle, so such operations may be granted on consecutive cycles. Code 3 occupies that unit for two cycles, so a multiply-add user offered in the next cycle waits 1.
- R4: Code 4 occupies the divide unit for 14 cycles and code 5 occupies it for 28 cycles. A divide-unit user offered k cycles after such a grant waits 14-k or 28-k respectively.
- R5: Codes 6 and 8 use load/store slot 1 at offset 0 and slot 2 at offset 1. Codes 7 and 9 use all three slots at offset 0, slots 2 and 3 at offset 1, and slot 3 at offset 2. A code 7 right after a code 6 waits 1, and a code 7 right after a code 7 waits 2. Two code 6 in a row do not wait.
- R6: Code 10 waits until both the multiply-add unit and the divide unit are idle. Its wait is the larger of their remaining busy times.
- R7: Result latencies are 5 for codes 0, 1 and 2, 6 for code 3, 18 for code 4, 32 for code 5, 4 for code 6 and 5 for code 7. A consumer that is not arithmetic (codes 2, 8, 9) may start no earlier than that many cycles after the producer's grant.
- R8: Arithmetic consumers (codes 0, 1, 3, 4, 5) see every latency reduced by one cycle.
- R9: wait_cycles is the maximum of the structural wait and the data wait, and issue_go is high exactly when the candidate is valid, core_hold is low and wait_cycles is 0.
- R10: A new grant that writes a register whose result is still pending keeps the later of the two ready times.
- R11: Codes 6, 7 and 10 read no source register, and codes 8 and 9 read only src_a. Pending results in the registers that are not read do not delay the candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A candidate instruction is presented |
| req_op | input | 4 | Operation class code (see R1) |
| req_src_a | input | 5 | First source register number |
| req_src_b | input | 5 | Second source register number |
| req_dst | input | 5 | Destination register number |
| core_hold | input | 1 | Core held in its first execute stage |
| issue_go | output | 1 | Candidate is granted this cycle |
| issue_stall | output | 1 | Candidate is valid but not granted |
| wait_cycles | output | 5 | Cycles until the candidate could be granted |

## Verification
The bench builds the block with its defaults: 32 registers and a 5-bit countdown. At that width the longest latency of the double divide (a countdown of 31) is reachable, and so is the 27-cycle divide-unit wait, without wrapping. The directed part places each producer against arithmetic and non-arithmetic consumers at known offsets. The random part restricts register numbers to 0 through 7 so that data hazards, register overwrites and slot collisions pile on top of each other, together with random core holds.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;

    localparam int LS_SLOTS = 3;
    localparam int LS_SPAN  = 3;
    localparam int MAC_W    = 2;
    localparam int DIV_W    = 5;
    localparam int LAT_W    = 6;

    typedef enum logic [3:0] {
        OP_FAST  = 4'd0,
        OP_ARITH = 4'd1,
        OP_CVT   = 4'd2,
        OP_DMUL  = 4'd3,
        OP_DIVS  = 4'd4,
        OP_DIVD  = 4'd5,
        OP_LDS   = 4'd6,
        OP_LDD   = 4'd7,
        OP_STS   = 4'd8,
        OP_STD   = 4'd9,
        OP_FLAG  = 4'd10
    } fp_op_e;

    // bit k of a row: slot busy k cycles after issue
    typedef logic [LS_SPAN-1:0] ls_row_t;

    typedef struct packed {
        logic [MAC_W-1:0]              mac_len;
        logic [DIV_W-1:0]              div_len;
        ls_row_t [LS_SLOTS-1:0]        ls_req;
        logic                          flag_sync;
    } unit_need_t;

    typedef struct packed {
        logic [LAT_W-1:0] lat;
        logic             wr;
        logic             rd_a;
        logic             rd_b;
        logic             fwd_use;
    } reg_need_t;

    typedef struct packed {
        unit_need_t u;
        reg_need_t  r;
    } op_prof_t;

    function automatic op_prof_t op_profile(input logic [3:0] code);
        op_prof_t p;
        p = '0;
        case (fp_op_e'(code))
            OP_FAST, OP_ARITH, OP_CVT: begin
                p.u.mac_len = 2'd1;
                p.r.lat     = 6'd5;
                p.r.wr      = 1'b1;
                p.r.rd_a    = 1'b1;
                p.r.rd_b    = 1'b1;
                p.r.fwd_use = (fp_op_e'(code) != OP_CVT);
            end
            OP_DMUL: begin
                p.u.mac_len = 2'd2;
                p.r.lat     = 6'd6;
                p.r.wr      = 1'b1;
                p.r.rd_a    = 1'b1;
                p.r.rd_b    = 1'b1;
                p.r.fwd_use = 1'b1;
            end
            OP_DIVS: begin
                p.u.div_len = 5'd14;
                p.r.lat     = 6'd18;
                p.r.wr      = 1'b1;
                p.r.rd_a    = 1'b1;
                p.r.rd_b    = 1'b1;
                p.r.fwd_use = 1'b1;
            end
            OP_DIVD: begin
                p.u.mac_len = 2'd1;
                p.u.div_len = 5'd28;
                p.r.lat     = 6'd32;
                p.r.wr      = 1'b1;
                p.r.rd_a    = 1'b1;
                p.r.rd_b    = 1'b1;
                p.r.fwd_use = 1'b1;
            end
            OP_LDS, OP_STS: begin
                p.u.ls_req[0] = 3'b001;
                p.u.ls_req[1] = 3'b010;
                if (fp_op_e'(code) == OP_LDS) begin
                    p.r.lat = 6'd4;
                    p.r.wr  = 1'b1;
                end else begin
                    p.r.rd_a = 1'b1;
                end
            end
            OP_LDD, OP_STD: begin
                p.u.ls_req[0] = 3'b001;
                p.u.ls_req[1] = 3'b011;
                p.u.ls_req[2] = 3'b111;
                if (fp_op_e'(code) == OP_LDD) begin
                    p.r.lat = 6'd5;
                    p.r.wr  = 1'b1;
                end else begin
                    p.r.rd_a = 1'b1;
                end
            end
            OP_FLAG: begin
                p.u.flag_sync = 1'b1;
            end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/fpsb_units.sv
module fpsb_units
    import fpsb_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  unit_need_t    need,
    input  logic          take,
    output logic [CW-1:0] s_wait
);

    logic [CW-1:0] mac_cnt;
    logic [CW-1:0] div_cnt;
    ls_row_t       occ [LS_SLOTS];
    logic [LS_SPAN-1:0] conf;
    logic [CW-1:0] mac_w, div_w, exec_w, ls_w;

    always_comb begin
        mac_w  = (need.mac_len != '0 || need.flag_sync) ? mac_cnt : '0;
        div_w  = (need.div_len != '0 || need.flag_sync) ? div_cnt : '0;
        exec_w = (mac_w > div_w) ? mac_w : div_w;
    end

    // slot conflict for each candidate delay
    always_comb begin
        for (int d = 0; d < LS_SPAN; d++) begin
            conf[d] = 1'b0;
            for (int s = 0; s < LS_SLOTS; s++) begin
                conf[d] = conf[d] | (|(occ[s] & ls_row_t'(need.ls_req[s] << d)));
            end
        end
    end

    always_comb begin
        ls_w = CW'(LS_SPAN);
        for (int d = LS_SPAN - 1; d >= 0; d--) begin
            if (!conf[d]) ls_w = CW'(d);
        end
    end

    assign s_wait = (exec_w > ls_w) ? exec_w : ls_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            mac_cnt <= '0;
            div_cnt <= '0;
        end else begin
            if (take && need.mac_len != '0)
                mac_cnt <= CW'(need.mac_len - MAC_W'(1));
            else if (mac_cnt != '0)
                mac_cnt <= mac_cnt - CW'(1);

            if (take && need.div_len != '0)
                div_cnt <= CW'(need.div_len - DIV_W'(1));
            else if (div_cnt != '0)
                div_cnt <= div_cnt - CW'(1);
        end
    end

    for (genvar s = 0; s < LS_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                occ[s] <= '0;
            else
                occ[s] <= (occ[s] >> 1) | (take ? (need.ls_req[s] >> 1) : '0);
        end

        a_r5_slot_free: assert property (@(posedge clk) disable iff (rst)
            take |-> ((occ[s] & need.ls_req[s]) == '0));
    end

    a_r3_mac_free: assert property (@(posedge clk) disable iff (rst)
        (take && need.mac_len != '0) |-> (mac_cnt == '0));

    a_r4_div_countdown: assert property (@(posedge clk) disable iff (rst)
        (!take && div_cnt != '0) |=> (div_cnt == $past(div_cnt) - CW'(1)));

    a_r6_flag_idle: assert property (@(posedge clk) disable iff (rst)
        (take && need.flag_sync) |-> (mac_cnt == '0 && div_cnt == '0));

endmodule

// File: rtl/fpsb_regs.sv
module fpsb_regs
    import fpsb_pkg::*;
#(
    parameter int NREG = 32,
    parameter int CW   = 5,
    parameter int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  reg_need_t     need,
    input  logic          take,
    input  logic [IW-1:0] src_a,
    input  logic [IW-1:0] src_b,
    input  logic [IW-1:0] dst,
    output logic [CW-1:0] d_wait
);

    logic [CW-1:0] cnt [NREG];
    logic [CW-1:0] new_cnt;
    logic [CW-1:0] wa, wb, dst_cnt;

    assign new_cnt = CW'(need.lat - LAT_W'(1));

    function automatic logic [CW-1:0] src_need(input logic [CW-1:0] c, input logic fwd);
        if (fwd && c != '0) return c - CW'(1);
        if (fwd) return '0;
        return c;
    endfunction

    always_comb begin
        wa      = need.rd_a ? src_need(cnt[src_a], need.fwd_use) : '0;
        wb      = need.rd_b ? src_need(cnt[src_b], need.fwd_use) : '0;
        d_wait  = (wa > wb) ? wa : wb;
        dst_cnt = cnt[dst];
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [CW-1:0] dec;
        assign dec = (cnt[i] != '0) ? cnt[i] - CW'(1) : '0;

        always_ff @(posedge clk) begin
            if (rst)
                cnt[i] <= '0;
            else if (take && need.wr && dst == IW'(i))
                cnt[i] <= (dec > new_cnt) ? dec : new_cnt;
            else
                cnt[i] <= dec;
        end
    end

    a_r7_src_clear: assert property (@(posedge clk) disable iff (rst)
        (take && need.rd_a && !need.fwd_use) |-> (cnt[src_a] == '0));

    a_r8_fwd_window: assert property (@(posedge clk) disable iff (rst)
        (take && need.rd_a && need.fwd_use) |-> (cnt[src_a] <= CW'(1)));

    a_r10_keep_longer: assert property (@(posedge clk) disable iff (rst)
        (take && need.wr) |=> (cnt[$past(dst)] >= $past(new_cnt))
            && (({1'b0, cnt[$past(dst)]} + 1'b1) >= {1'b0, $past(dst_cnt)}));

endmodule

// File: rtl/fpsb_issue.sv
module fpsb_issue
    import fpsb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int CNT_W    = 5,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [3:0]       req_op,
    input  logic [IDX_W-1:0] req_src_a,
    input  logic [IDX_W-1:0] req_src_b,
    input  logic [IDX_W-1:0] req_dst,
    input  logic             core_hold,
    output logic             issue_go,
    output logic             issue_stall,
    output logic [CNT_W-1:0] wait_cycles
);

    op_prof_t         prof;
    logic [CNT_W-1:0] s_wait;
    logic [CNT_W-1:0] d_wait;

    assign prof = op_profile(req_op);

    fpsb_units #(.CW(CNT_W)) u_units (
        .clk    (clk),
        .rst    (rst),
        .need   (prof.u),
        .take   (issue_go),
        .s_wait (s_wait)
    );

    fpsb_regs #(.NREG(NUM_REGS), .CW(CNT_W), .IW(IDX_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .need   (prof.r),
        .take   (issue_go),
        .src_a  (req_src_a),
        .src_b  (req_src_b),
        .dst    (req_dst),
        .d_wait (d_wait)
    );

    assign wait_cycles = (s_wait > d_wait) ? s_wait : d_wait;
    assign issue_go    = req_valid && !core_hold && (wait_cycles == '0);
    assign issue_stall = req_valid && !issue_go;

    a_r2_hold_blocks: assert property (@(posedge clk) disable iff (rst)
        core_hold |-> !issue_go);

    a_r2_held_stalls: assert property (@(posedge clk) disable iff (rst)
        (req_valid && core_hold) |-> issue_stall);

endmodule

// File: tb/fpsb_issue_tb.sv
`timescale 1ns/1ps
module fpsb_issue_tb;

    localparam int C_FAST = 0, C_ARITH = 1, C_CVT = 2, C_DMUL = 3, C_DIVS = 4,
                   C_DIVD = 5, C_LDS = 6, C_LDD = 7, C_STS = 8, C_STD = 9, C_FLAG = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [3:0] req_op = '0;
    logic [4:0] req_src_a = '0, req_src_b = '0, req_dst = '0;
    logic       core_hold = 1'b0;
    logic       issue_go, issue_stall;
    logic [4:0] wait_cycles;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state in absolute cycle numbers
    int now;
    int rdy [32];
    int mac_free, div_free;
    bit lsb [3][256];

    always #5 clk = ~clk;

    fpsb_issue u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_src_a(req_src_a), .req_src_b(req_src_b), .req_dst(req_dst),
        .core_hold(core_hold), .issue_go(issue_go), .issue_stall(issue_stall),
        .wait_cycles(wait_cycles)
    );

    function automatic void bprof(input int c, output int ml, output int dl, output int lat,
                                  output bit wr, output bit ra, output bit rb,
                                  output bit fw, output bit fl);
        ml = 0; dl = 0; lat = 0; wr = 0; ra = 0; rb = 0; fw = 0; fl = 0;
        case (c)
            C_FAST, C_ARITH: begin ml = 1; lat = 5; wr = 1; ra = 1; rb = 1; fw = 1; end
            C_CVT:  begin ml = 1; lat = 5; wr = 1; ra = 1; rb = 1; end
            C_DMUL: begin ml = 2; lat = 6; wr = 1; ra = 1; rb = 1; fw = 1; end
            C_DIVS: begin dl = 14; lat = 18; wr = 1; ra = 1; rb = 1; fw = 1; end
            C_DIVD: begin ml = 1; dl = 28; lat = 32; wr = 1; ra = 1; rb = 1; fw = 1; end
            C_LDS:  begin lat = 4; wr = 1; end
            C_LDD:  begin lat = 5; wr = 1; end
            C_STS, C_STD: ra = 1;
            C_FLAG: fl = 1;
            default: ;
        endcase
    endfunction

    function automatic bit ls_use(input int c, input int s, input int k);
        if (c == C_LDS || c == C_STS) return (s == 0 && k == 0) || (s == 1 && k == 1);
        if (c == C_LDD || c == C_STD) return k <= s;
        return 0;
    endfunction

    function automatic int exp_wait(input int c, input int a, input int b);
        int ml, dl, lat, w, d, av;
        bit wr, ra, rb, fw, fl, conflict;
        bprof(c, ml, dl, lat, wr, ra, rb, fw, fl);
        w = 0;
        if ((ml > 0 || fl) && mac_free - now > w) w = mac_free - now;
        if ((dl > 0 || fl) && div_free - now > w) w = div_free - now;
        d = 0;
        forever begin
            conflict = 0;
            for (int s = 0; s < 3; s++)
                for (int k = 0; k < 3; k++)
                    if (ls_use(c, s, k) && lsb[s][(now + d + k) % 256]) conflict = 1;
            if (!conflict) break;
            d++;
        end
        if (d > w) w = d;
        if (ra) begin av = rdy[a] - (fw ? 1 : 0); if (av - now > w) w = av - now; end
        if (rb) begin av = rdy[b] - (fw ? 1 : 0); if (av - now > w) w = av - now; end
        return w;
    endfunction

    task automatic commit(input int c, input int dreg);
        int ml, dl, lat;
        bit wr, ra, rb, fw, fl;
        bprof(c, ml, dl, lat, wr, ra, rb, fw, fl);
        if (ml > 0) mac_free = now + ml;
        if (dl > 0) div_free = now + dl;
        for (int s = 0; s < 3; s++)
            for (int k = 0; k < 3; k++)
                if (ls_use(c, s, k)) lsb[s][(now + k) % 256] = 1;
        if (wr && now + lat > rdy[dreg]) rdy[dreg] = now + lat;
    endtask

    task automatic model_reset();
        now = 0; mac_free = 0; div_free = 0;
        for (int i = 0; i < 32; i++) rdy[i] = 0;
        for (int s = 0; s < 3; s++)
            for (int i = 0; i < 256; i++) lsb[s][i] = 0;
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at step %0d", tag, what, act, exp, now);
        end
    endtask

    task automatic step(input string tag, input bit v, input int c, input int a, input int b,
                        input int dreg, input bit hold, input int lit);
        int ew;
        bit eg;
        @(negedge clk);
        req_valid = v; req_op = 4'(c); req_src_a = 5'(a); req_src_b = 5'(b);
        req_dst = 5'(dreg); core_hold = hold;
        #1;
        ew = exp_wait(c, a, b);
        eg = v && !hold && ew == 0;
        chk(tag, "issue_go", int'(issue_go), int'(eg));
        chk(tag, "issue_stall", int'(issue_stall), int'(v && !eg));
        chk(tag, "wait_cycles", int'(wait_cycles), ew);
        if (lit >= 0) chk(tag, "wait_cycles(direct)", int'(wait_cycles), lit);
        if (eg) commit(c, dreg);
        @(posedge clk);
        for (int s = 0; s < 3; s++) lsb[s][now % 256] = 0;
        now++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step("R9", 0, C_FAST, 0, 0, 0, 0, -1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; req_valid = 0; core_hold = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    initial begin
        #(1ms);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            done = 1;
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        chk("R1", "reset issue_go", int'(issue_go), 0);
        chk("R1", "reset issue_stall", int'(issue_stall), 0);
        chk("R1", "reset wait_cycles", int'(wait_cycles), 0);

        // R1 / R3: mac back to back, then double multiply
        step("R1", 1, C_FAST, 2, 3, 1, 0, 0);
        step("R3", 1, C_FAST, 5, 6, 4, 0, 0);
        step("R3", 1, C_DMUL, 5, 6, 7, 0, 0);
        step("R3", 1, C_ARITH, 9, 10, 8, 0, 1);
        step("R3", 1, C_ARITH, 9, 10, 8, 0, 0);
        idle(40);

        // R2: held candidate reserves nothing
        step("R2", 1, C_DMUL, 2, 3, 9, 1, 0);
        step("R2", 1, C_FAST, 2, 3, 10, 0, 0);
        step("R2", 1, C_CVT, 9, 0, 11, 0, 0);
        idle(10);

        // R4: divide unit occupancy
        step("R4", 1, C_DIVS, 2, 3, 12, 0, 0);
        step("R4", 1, C_DIVD, 2, 3, 13, 0, 13);
        idle(11);
        step("R4", 1, C_DIVD, 2, 3, 13, 0, 1);
        step("R4", 1, C_DIVD, 2, 3, 13, 0, 0);
        step("R3", 1, C_FAST, 2, 3, 14, 0, 0);
        step("R4", 1, C_DIVS, 2, 3, 15, 0, 26);

        // R6: flag transfer waits for both units
        step("R6", 1, C_FLAG, 0, 0, 0, 0, 25);
        idle(30);
        step("R6", 1, C_DMUL, 2, 3, 16, 0, 0);
        step("R6", 1, C_FLAG, 0, 0, 0, 0, 1);
        step("R6", 1, C_FLAG, 0, 0, 0, 0, 0);

        // R5: load/store slots
        idle(5);
        step("R5", 1, C_LDS, 0, 0, 17, 0, 0);
        step("R5", 1, C_LDD, 0, 0, 18, 0, 1);
        step("R5", 1, C_LDD, 0, 0, 18, 0, 0);
        step("R5", 1, C_LDD, 0, 0, 19, 0, 2);
        idle(5);
        step("R5", 1, C_LDS, 0, 0, 20, 0, 0);
        step("R5", 1, C_LDS, 0, 0, 21, 0, 0);

        // R7 / R8: latency to plain and arithmetic consumers
        idle(5);
        step("R7", 1, C_LDS, 0, 0, 22, 0, 0);
        step("R7", 1, C_CVT, 22, 0, 23, 0, 3);
        step("R8", 1, C_ARITH, 22, 0, 24, 0, 1);
        step("R8", 1, C_ARITH, 22, 0, 24, 0, 0);
        step("R7", 1, C_STS, 22, 0, 0, 0, 0);
        step("R8", 1, C_DIVD, 2, 3, 25, 0, 0);
        step("R8", 1, C_FAST, 25, 2, 26, 0, 30);
        step("R7", 1, C_CVT, 25, 0, 26, 0, 30);

        // R9: data wait dominates, then structural wait dominates
        idle(35);
        step("R9", 1, C_DIVS, 2, 3, 27, 0, 0);
        step("R9", 1, C_DIVS, 27, 2, 28, 0, 16);
        step("R9", 1, C_DIVS, 2, 3, 28, 0, 12);

        // R10: overwrite keeps the later ready time
        idle(20);
        step("R10", 1, C_DIVD, 2, 3, 29, 0, 0);
        step("R10", 1, C_FAST, 2, 3, 29, 0, 0);
        step("R10", 1, C_CVT, 29, 0, 30, 0, 30);

        // R11: unread source fields have no effect
        step("R11", 1, C_LDD, 29, 29, 31, 0, 0);
        step("R11", 1, C_STS, 0, 29, 0, 0, 0);
        step("R11", 1, C_STS, 29, 0, 0, 0, 27);

        // R1: reset in the middle clears all bookings
        do_reset();
        step("R1", 1, C_DIVS, 2, 3, 1, 0, 0);
        step("R1", 1, C_DIVS, 2, 3, 1, 0, 13);

        // R9: random mix
        for (int i = 0; i < 3000; i++) begin
            step("R9", ($urandom % 10) != 0, $urandom % 11, $urandom % 8, $urandom % 8,
                 $urandom % 8, ($urandom % 10) == 0, -1);
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule